// File: doc/BRIEF.md
# Symbol Match Mask Builder

The block holds a short pattern of symbols and a longer reference sequence of symbols. It builds a two-dimensional match table. Each bit of the table is 1 when one pattern symbol equals one reference symbol. There is one row per pattern symbol, and each row has one bit per reference symbol. The block has only one row of equality comparators, one per reference symbol. It computes a single table row in each clock cycle, so a full table takes one cycle per pattern symbol plus one start cycle.

A host first writes the pattern and reference symbols through two indexed write ports. It then holds the mask-enable input high and pulses start. When the done pulse appears, the host drops mask-enable. It can then read any row by address through a registered read port that has a valid strobe.

Top module: `mmask_gen`

## Requirements
- R1: After generation, bit j of table row i is 1 exactly when pattern symbol i equals reference symbol j, and 0 otherwise. Read data bit j maps to reference symbol j, and the read address selects pattern symbol i.
- R2: The pattern length and the reference length are separate parameters. The defaults are 3 pattern symbols of 4 bits and 5 reference symbols.
- R3: A start pulse sampled while mask-enable is high sets the row counter to 0. A start pulse sampled while mask-enable is low has no effect. After start, each clock edge with mask-enable high writes one row, in ascending order. When mask-enable is low, the sequence pauses and the table is not changed.
- R4: `done` is high for exactly one cycle. That cycle follows the clock edge that writes the last row.
- R5: When `rd_en` is high, `mask_en` is low and `rd_addr` is below the pattern length, the selected row appears on `rd_data` one cycle later, with `rd_valid` high.
- R6: In every cycle where `rd_valid` is low, `rd_data` is all zeros.
- R7: Mask-enable takes priority over read-enable. A read requested while `mask_en` is high gives `rd_valid` low and zero data.
- R8: An address equal to or above the pattern length gives `rd_valid` low and zero data.
- R9: Symbol writes are ignored from the start edge until the edge that writes the last row. Writes whose index is out of range are also ignored.
- R10: After reset, every symbol and every table bit is zero, and `rd_valid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| pat_we | input | 1 | Pattern symbol write strobe |
| pat_idx | input | PIW (2) | Pattern symbol index |
| pat_sym | input | SYM_W (4) | Pattern symbol value |
| ref_we | input | 1 | Reference symbol write strobe |
| ref_idx | input | RIW (3) | Reference symbol index |
| ref_sym | input | SYM_W (4) | Reference symbol value |
| mask_en | input | 1 | Mask generation enable |
| start | input | 1 | Restart generation at row 0 (needs mask_en) |
| rd_en | input | 1 | Row read request |
| rd_addr | input | PIW (2) | Row address (pattern symbol index) |
| rd_data | output | REF_LEN (5) | Registered row contents |
| rd_valid | output | 1 | Read data valid strobe |
| done | output | 1 | One-cycle pulse after the last row is written |

## Verification
The assertions check on every cycle that zero data goes with an invalid read and that `done` never lasts two cycles. They also check that a valid read can only follow an accepted request, and that mask-enable or an out-of-range address always suppresses the next read. Only the bench's reference model can show that the table contents are correct for each pattern. The same holds for the pause behaviour when mask-enable drops during a run, and for the rule that symbol writes during a run leave the table unchanged.

// File: rtl/mmask_pkg.sv
package mmask_pkg;
    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;
endpackage

// File: rtl/mmask_seq.sv
// Row sequencer: one pattern row per enabled cycle after a start pulse.
module mmask_seq
    import mmask_pkg::*;
#(
    parameter int PAT_LEN = 3,
    parameter int IW      = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mask_en,
    input  logic          start,
    output logic          busy,
    output logic          row_wr,
    output logic [IW-1:0] row_idx,
    output logic          done
);
    localparam logic [IW-1:0] LAST_ROW = IW'(PAT_LEN - 1);

    typedef struct packed {
        seq_state_e    st;
        logic [IW-1:0] row;
        logic          done;
    } seq_t;

    seq_t seq_d, seq_q;
    logic wr_d;

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        wr_d       = 1'b0;
        if (mask_en && start) begin
            seq_d.st  = SEQ_RUN;
            seq_d.row = '0;
        end else if (mask_en && seq_q.st == SEQ_RUN) begin
            wr_d = 1'b1;
            if (seq_q.row == LAST_ROW) begin
                seq_d.st   = SEQ_IDLE;
                seq_d.row  = '0;
                seq_d.done = 1'b1;
            end else begin
                seq_d.row = seq_q.row + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '{st: SEQ_IDLE, row: '0, done: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy    = (seq_q.st == SEQ_RUN);
    assign row_wr  = wr_d;
    assign row_idx = seq_q.row;
    assign done    = seq_q.done;
endmodule

// File: rtl/mmask_symbols.sv
// Pattern and reference symbol registers; writes locked while a run is active.
module mmask_symbols #(
    parameter int SYM_W   = 4,
    parameter int PAT_LEN = 3,
    parameter int REF_LEN = 5,
    parameter int PIW     = 2,
    parameter int RIW     = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       lock,
    input  logic                       pat_we,
    input  logic [PIW-1:0]             pat_idx,
    input  logic [SYM_W-1:0]           pat_sym,
    input  logic                       ref_we,
    input  logic [RIW-1:0]             ref_idx,
    input  logic [SYM_W-1:0]           ref_sym,
    input  logic [PIW-1:0]             row_idx,
    output logic [SYM_W-1:0]           cur_pat,
    output logic [REF_LEN*SYM_W-1:0]   ref_flat
);
    localparam logic [PIW:0] P_LIM = (PIW+1)'(PAT_LEN);
    localparam logic [RIW:0] R_LIM = (RIW+1)'(REF_LEN);

    typedef struct packed {
        logic [PAT_LEN-1:0][SYM_W-1:0] pat;
        logic [REF_LEN-1:0][SYM_W-1:0] refs;
    } sym_t;

    sym_t sym_d, sym_q;

    always_comb begin
        sym_d = sym_q;
        if (!lock && pat_we && ({1'b0, pat_idx} < P_LIM)) begin
            sym_d.pat[pat_idx] = pat_sym;
        end
        if (!lock && ref_we && ({1'b0, ref_idx} < R_LIM)) begin
            sym_d.refs[ref_idx] = ref_sym;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sym_q <= '0;
        end else begin
            sym_q <= sym_d;
        end
    end

    assign cur_pat  = sym_q.pat[row_idx];
    assign ref_flat = sym_q.refs;
endmodule

// File: rtl/mmask_cmp_row.sv
// The single shared row of equality comparators.
module mmask_cmp_row #(
    parameter int SYM_W   = 4,
    parameter int REF_LEN = 5
) (
    input  logic [SYM_W-1:0]         cur_pat,
    input  logic [REF_LEN*SYM_W-1:0] ref_flat,
    output logic [REF_LEN-1:0]       hit
);
    for (genvar j = 0; j < REF_LEN; j++) begin : g_cmp
        assign hit[j] = (ref_flat[j*SYM_W +: SYM_W] == cur_pat);
    end
endmodule

// File: rtl/mmask_table.sv
// Match table storage with a registered, addressed read port.
module mmask_table #(
    parameter int PAT_LEN = 3,
    parameter int REF_LEN = 5,
    parameter int AW      = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               row_wr,
    input  logic [AW-1:0]      row_idx,
    input  logic [REF_LEN-1:0] row_bits,
    input  logic               rd_req,
    input  logic [AW-1:0]      rd_addr,
    output logic [REF_LEN-1:0] rd_data,
    output logic               rd_valid
);
    localparam logic [AW:0] A_LIM = (AW+1)'(PAT_LEN);

    typedef struct packed {
        logic [PAT_LEN-1:0][REF_LEN-1:0] tbl;
        logic [REF_LEN-1:0]              data;
        logic                            valid;
    } tab_t;

    tab_t tab_d, tab_q;

    always_comb begin
        tab_d       = tab_q;
        tab_d.valid = 1'b0;
        tab_d.data  = '0;
        if (row_wr) begin
            tab_d.tbl[row_idx] = row_bits;
        end
        if (rd_req && ({1'b0, rd_addr} < A_LIM)) begin
            tab_d.valid = 1'b1;
            tab_d.data  = tab_q.tbl[rd_addr];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tab_q <= '0;
        end else begin
            tab_q <= tab_d;
        end
    end

    assign rd_data  = tab_q.data;
    assign rd_valid = tab_q.valid;
endmodule

// File: rtl/mmask_gen.sv
module mmask_gen #(
    parameter int SYM_W   = 4,
    parameter int PAT_LEN = 3,
    parameter int REF_LEN = 5,
    localparam int PIW    = (PAT_LEN > 1) ? $clog2(PAT_LEN) : 1,
    localparam int RIW    = (REF_LEN > 1) ? $clog2(REF_LEN) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pat_we,
    input  logic [PIW-1:0]     pat_idx,
    input  logic [SYM_W-1:0]   pat_sym,
    input  logic               ref_we,
    input  logic [RIW-1:0]     ref_idx,
    input  logic [SYM_W-1:0]   ref_sym,
    input  logic               mask_en,
    input  logic               start,
    input  logic               rd_en,
    input  logic [PIW-1:0]     rd_addr,
    output logic [REF_LEN-1:0] rd_data,
    output logic               rd_valid,
    output logic               done
);
    logic                     busy;
    logic                     row_wr;
    logic [PIW-1:0]           row_idx;
    logic [SYM_W-1:0]         cur_pat;
    logic [REF_LEN*SYM_W-1:0] ref_flat;
    logic [REF_LEN-1:0]       hit;

    mmask_seq #(.PAT_LEN(PAT_LEN), .IW(PIW)) u_seq (
        .clk(clk), .rst_n(rst_n), .mask_en(mask_en), .start(start),
        .busy(busy), .row_wr(row_wr), .row_idx(row_idx), .done(done)
    );

    mmask_symbols #(
        .SYM_W(SYM_W), .PAT_LEN(PAT_LEN), .REF_LEN(REF_LEN), .PIW(PIW), .RIW(RIW)
    ) u_sym (
        .clk(clk), .rst_n(rst_n), .lock(busy),
        .pat_we(pat_we), .pat_idx(pat_idx), .pat_sym(pat_sym),
        .ref_we(ref_we), .ref_idx(ref_idx), .ref_sym(ref_sym),
        .row_idx(row_idx), .cur_pat(cur_pat), .ref_flat(ref_flat)
    );

    mmask_cmp_row #(.SYM_W(SYM_W), .REF_LEN(REF_LEN)) u_cmp (
        .cur_pat(cur_pat), .ref_flat(ref_flat), .hit(hit)
    );

    mmask_table #(.PAT_LEN(PAT_LEN), .REF_LEN(REF_LEN), .AW(PIW)) u_tab (
        .clk(clk), .rst_n(rst_n), .row_wr(row_wr), .row_idx(row_idx),
        .row_bits(hit), .rd_req(rd_en && !mask_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );
endmodule

// File: rtl/mmask_chk.sv
module mmask_chk #(
    parameter int PAT_LEN = 3,
    parameter int REF_LEN = 5,
    parameter int PIW     = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               mask_en,
    input logic               rd_en,
    input logic [PIW-1:0]     rd_addr,
    input logic [REF_LEN-1:0] rd_data,
    input logic               rd_valid,
    input logic               done
);
    localparam logic [PIW:0] A_LIM = (PIW+1)'(PAT_LEN);

    p_zero_when_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> (rd_data == '0));

    p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_mask_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mask_en |=> !rd_valid);

    p_addr_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && ({1'b0, rd_addr} >= A_LIM)) |=> !rd_valid);

    p_valid_needs_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ($past(rd_en) && !$past(mask_en)));

    p_done_needs_enable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(mask_en));
endmodule

bind mmask_gen mmask_chk #(.PAT_LEN(PAT_LEN), .REF_LEN(REF_LEN), .PIW(PIW)) u_chk (
    .clk(clk), .rst_n(rst_n), .mask_en(mask_en), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid), .done(done)
);

// File: tb/sim_mmask_gen.sv
`timescale 1ns/1ps
module sim_mmask_gen;
    localparam int W = 4;
    localparam int P = 3;
    localparam int R = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pat_we = 0, ref_we = 0, mask_en = 0, start = 0, rd_en = 0;
    logic [1:0] pat_idx = '0, rd_addr = '0;
    logic [2:0] ref_idx = '0;
    logic [W-1:0] pat_sym = '0, ref_sym = '0;
    logic [R-1:0] rd_data;
    logic rd_valid, done;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    string phase = "R10";

    always #2.5 clk = ~clk;

    mmask_gen #(.SYM_W(W), .PAT_LEN(P), .REF_LEN(R)) u0 (
        .clk(clk), .rst_n(rst_n),
        .pat_we(pat_we), .pat_idx(pat_idx), .pat_sym(pat_sym),
        .ref_we(ref_we), .ref_idx(ref_idx), .ref_sym(ref_sym),
        .mask_en(mask_en), .start(start),
        .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .rd_valid(rd_valid), .done(done)
    );

    // behavioural reference model
    int pat_m[P];
    int ref_m[R];
    logic [R-1:0] tbl_m[P];
    bit busy_m;
    int row_m;
    logic [R-1:0] e_data;
    logic e_valid, e_done;

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (pat_m[i]) begin pat_m[i] = 0; tbl_m[i] = '0; end
            foreach (ref_m[j]) ref_m[j] = 0;
            busy_m = 0; row_m = 0; e_data = '0; e_valid = 0; e_done = 0;
        end else begin
            bit was_busy;
            was_busy = busy_m;
            if (rd_en && !mask_en && int'(rd_addr) < P) begin
                e_valid = 1; e_data = tbl_m[rd_addr];
            end else begin
                e_valid = 0; e_data = '0;
            end
            e_done = 0;
            if (mask_en && start) begin
                busy_m = 1; row_m = 0;
            end else if (mask_en && busy_m) begin
                for (int j = 0; j < R; j++) tbl_m[row_m][j] = (pat_m[row_m] == ref_m[j]);
                if (row_m == P - 1) begin busy_m = 0; row_m = 0; e_done = 1; end
                else row_m++;
            end
            if (pat_we && !was_busy && int'(pat_idx) < P) pat_m[pat_idx] = int'(pat_sym);
            if (ref_we && !was_busy && int'(ref_idx) < R) ref_m[ref_idx] = int'(ref_sym);
        end
    end

    // cycle-by-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            total++;
            if (rd_valid !== e_valid || rd_data !== e_data || done !== e_done) begin
                bad++;
                $display("FAIL %s model: valid=%b data=%b done=%b expected valid=%b data=%b done=%b",
                         phase, rd_valid, rd_data, done, e_valid, e_data, e_done);
            end
        end
    end

    task automatic chk(input string tag, input logic [R-1:0] act, input logic [R-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic put_pat(input int i, input int v);
        pat_we = 1; pat_idx = 2'(i); pat_sym = W'(v);
        @(negedge clk); pat_we = 0;
    endtask

    task automatic put_ref(input int j, input int v);
        ref_we = 1; ref_idx = 3'(j); ref_sym = W'(v);
        @(negedge clk); ref_we = 0;
    endtask

    task automatic load(input int p0, p1, p2, r0, r1, r2, r3, r4);
        put_pat(0, p0); put_pat(1, p1); put_pat(2, p2);
        put_ref(0, r0); put_ref(1, r1); put_ref(2, r2); put_ref(3, r3); put_ref(4, r4);
    endtask

    task automatic run_gen(input string tag);
        mask_en = 1; start = 1;
        @(negedge clk); start = 0;
        repeat (P) @(negedge clk);
        chk(tag, R'(done), R'(1));
        mask_en = 0;
        @(negedge clk);
        chk(tag, R'(done), R'(0));
    endtask

    task automatic rd(input int a, input logic [R-1:0] exp, input logic expv, input string tag);
        rd_en = 1; rd_addr = 2'(a);
        @(negedge clk); rd_en = 0;
        chk(tag, rd_data, exp);
        chk(tag, R'(rd_valid), R'(expv));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R10: reset state
        phase = "R10";
        chk("R10", rd_data, '0);
        chk("R10", R'({rd_valid, done}), '0);
        rd(0, '0, 1, "R10"); rd(2, '0, 1, "R10");

        // R2: independent lengths at defaults
        phase = "R2";
        chk("R2", R'($bits(rd_data)), R'(R));

        // R1 / R5: main function
        phase = "R1";
        load(3, 7, 3, 3, 1, 7, 3, 9);
        run_gen("R4");
        rd(0, 5'b01001, 1, "R1"); rd(1, 5'b00100, 1, "R5"); rd(2, 5'b01001, 1, "R1");

        // R8: out-of-range address
        phase = "R8";
        rd(3, '0, 0, "R8");

        // R6: idle cycles
        phase = "R6";
        repeat (3) @(negedge clk);
        chk("R6", rd_data, '0);

        // R7: read blocked by mask enable
        phase = "R7";
        mask_en = 1;
        rd(1, '0, 0, "R7");
        mask_en = 0;
        @(negedge clk);

        // R3: pause mid-run and start without mask enable
        phase = "R3";
        load(1, 1, 1, 0, 2, 3, 4, 5);
        start = 1; @(negedge clk); start = 0;
        repeat (2) @(negedge clk);
        chk("R3", R'(done), '0);
        mask_en = 1; start = 1; @(negedge clk); start = 0;
        @(negedge clk);
        mask_en = 0; repeat (3) @(negedge clk);
        chk("R3", R'(done), '0);
        mask_en = 1; repeat (2) @(negedge clk);
        chk("R3", R'(done), R'(1));
        mask_en = 0; @(negedge clk);
        rd(0, '0, 1, "R3"); rd(2, '0, 1, "R3");

        // R9: writes during a run are ignored
        phase = "R9";
        load(2, 2, 2, 2, 0, 2, 0, 2);
        mask_en = 1; start = 1; @(negedge clk); start = 0;
        pat_we = 1; pat_idx = 0; pat_sym = 4'd0;
        ref_we = 1; ref_idx = 1; ref_sym = 4'd2;
        @(negedge clk); pat_we = 0; ref_we = 0;
        repeat (P - 1) @(negedge clk);
        chk("R9", R'(done), R'(1));
        mask_en = 0; @(negedge clk);
        run_gen("R9");
        rd(0, 5'b10101, 1, "R9"); rd(1, 5'b10101, 1, "R9");

        // R1: all-hit pattern
        phase = "R1";
        load(6, 6, 6, 6, 6, 6, 6, 6);
        run_gen("R1");
        rd(1, 5'b11111, 1, "R1");

        repeat (2) @(negedge clk);
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule